// File: doc/BRIEF.md
# Prioritised Interrupt Entry and Return Sequencer

This block sits beside the fetch unit of a small 8-bit processor with a 16-bit program counter. It watches five interrupt request lines, each with its own enable bit and priority bit, plus a global enable. When a request may be taken, it stalls the processor, saves the current program counter into stack memory, marks the new service level and redirects the processor to the handler's vector. When the processor signals a return from interrupt, the block reads the saved program counter back from the stack and hands it to the fetch unit. It also drops the service level that the matching entry raised.

Sources are numbered 0 to 4 (two external pins, two timers and a serial port, in that order). Source i has handler address 0x0003 + 8*i, giving 0x0003, 0x000B, 0x0013, 0x001B and 0x0023. The stack grows toward higher addresses, and the stack pointer always addresses the most recently written byte. Service state is two nested flags: one for a low-priority handler in progress and one for a high-priority handler. A low handler can be interrupted by a high request, and a high handler cannot be interrupted by anything.

The sequencer has seven states. IDLE waits. PUSH_LO writes the low PC byte. PUSH_HI writes the high PC byte. VECTOR loads the handler address. POP_HI reads the high byte back. POP_LO reads the low byte back. RESUME loads the restored address. Transitions: IDLE to PUSH_LO on an accepted request, IDLE to POP_HI on a return strobe, PUSH_LO to PUSH_HI, PUSH_HI to VECTOR, VECTOR to IDLE, POP_HI to POP_LO, POP_LO to RESUME, RESUME to IDLE. Every state other than IDLE lasts exactly one cycle.

Top module: `irq_seq`

## Requirements
- R1: A request line is a candidate only when its own enable bit and the global enable are both 1. With either enable at 0, the line never starts an entry sequence.
- R2: After acceptance, the block writes two bytes on two consecutive cycles. First it writes the low PC byte at address SP+1, then the high PC byte at SP+2, where SP is the value before entry. SP ends two higher.
- R3: On the cycle after the high-byte write, `pc_load_o` is 1 for exactly one cycle, and `pc_val_o` carries 0x0003 + 8*i for accepted source i.
- R4: Among candidates of equal priority, the lowest-numbered source wins (polling order 0,1,2,3,4).
- R5: A candidate with its priority bit at 1 (high) beats any candidate with its priority bit at 0 (low), regardless of source number.
- R6: While a low handler is in service (`in_service_o` bit 0), further low requests are not taken, but a high request is taken. While a high handler is in service (`in_service_o` bit 1), no request is taken.
- R7: A return strobe in IDLE reads the high byte at SP, then the low byte at SP-1, on two consecutive cycles. SP ends two lower. One cycle later, `pc_load_o` pulses with the restored 16-bit value.
- R8: Completing a return clears bit 1 of `in_service_o` if it is set; otherwise it clears bit 0. Completing an entry sets bit 1 for a high source and bit 0 for a low source.
- R9: `cpu_hold_o` is 1 in every state except IDLE.
- R10: After reset, SP is 0x07, `in_service_o` is 0, and neither the hold, PC load nor write strobe is asserted.
- R11: If a return strobe and an acceptable request arrive in the same IDLE cycle, the return runs first. The request is accepted in the IDLE cycle that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gie_i | input | 1 | Global interrupt enable |
| req_i | input | 5 | Request level per source |
| en_i | input | 5 | Enable per source |
| prio_i | input | 5 | Priority per source (1 = high) |
| pc_i | input | 16 | Current program counter, captured on acceptance |
| reti_i | input | 1 | Return-from-interrupt strobe |
| mem_addr_o | output | 8 | Stack memory address |
| mem_wdata_o | output | 8 | Stack memory write data |
| mem_we_o | output | 1 | Stack memory write enable |
| mem_rdata_i | input | 8 | Stack memory read data (combinational read) |
| sp_o | output | 8 | Current stack pointer |
| pc_load_o | output | 1 | One-cycle PC load strobe |
| pc_val_o | output | 16 | Value to load into the PC |
| in_service_o | output | 2 | Bit 0 low level in service, bit 1 high level in service |
| cpu_hold_o | output | 1 | Stall request to the processor |

## Verification
The bench checks every byte written to the stack model and every address used. A design that pushed the high byte first, or wrote below SP, would fail the round trip, because the return would come back with swapped bytes. The bench forms nested entries, low then high, and checks that equal- and lower-level requests stay ignored. A flat single in-service flag would either miss the high preemption or restore the wrong level on the first return. It also presents mixed-priority and multi-source request sets. An encoder that scanned from the top index, or ignored priority, would load the wrong vector. A return strobe that coincides with a fresh request must give a return sequence first; a design that favoured entry would push instead of pop.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PUSH_LO = 3'd1,
        ST_PUSH_HI = 3'd2,
        ST_VECTOR  = 3'd3,
        ST_POP_HI  = 3'd4,
        ST_POP_LO  = 3'd5,
        ST_RESUME  = 3'd6
    } seq_state_t;

endpackage

// File: rtl/irq_prienc.sv
module irq_prienc #(
    parameter int N  = 5,
    parameter int IW = 3
) (
    input  logic [N-1:0]  vec_i,
    output logic          hit_o,
    output logic [IW-1:0] idx_o
);
    // lowest index has the highest polling rank
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                hit_o = 1'b1;
                idx_o = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int NSRC = 5,
    parameter int IDXW = 3
) (
    input  logic [NSRC-1:0] req_i,
    input  logic [NSRC-1:0] en_i,
    input  logic [NSRC-1:0] prio_i,
    input  logic            gie_i,
    input  logic            blk_hi_i,
    input  logic            blk_lo_i,
    output logic            win_valid_o,
    output logic            win_hi_o,
    output logic [IDXW-1:0] win_idx_o
);
    logic [NSRC-1:0] armed;
    logic [NSRC-1:0] cand_hi;
    logic [NSRC-1:0] cand_lo;
    logic            hit_hi;
    logic            hit_lo;
    logic [IDXW-1:0] idx_hi;
    logic [IDXW-1:0] idx_lo;

    assign armed   = req_i & en_i & {NSRC{gie_i}};
    assign cand_hi = armed &  prio_i & {NSRC{~blk_hi_i}};
    assign cand_lo = armed & ~prio_i & {NSRC{~blk_lo_i}};

    irq_prienc #(.N(NSRC), .IW(IDXW)) enc_hi_i (
        .vec_i (cand_hi),
        .hit_o (hit_hi),
        .idx_o (idx_hi)
    );

    irq_prienc #(.N(NSRC), .IW(IDXW)) enc_lo_i (
        .vec_i (cand_lo),
        .hit_o (hit_lo),
        .idx_o (idx_lo)
    );

    assign win_valid_o = hit_hi | hit_lo;
    assign win_hi_o    = hit_hi;
    assign win_idx_o   = hit_hi ? idx_hi : idx_lo;
endmodule

// File: rtl/irq_level_track.sv
module irq_level_track (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_i,
    input  logic       set_hi_i,
    input  logic       clr_i,
    output logic [1:0] isr_o
);
    logic [1:0] isr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q <= 2'b00;
        end else if (set_i) begin
            if (set_hi_i) isr_q[1] <= 1'b1;
            else          isr_q[0] <= 1'b1;
        end else if (clr_i) begin
            if (isr_q[1]) isr_q[1] <= 1'b0;
            else          isr_q[0] <= 1'b0;
        end
    end

    assign isr_o = isr_q;
endmodule

// File: rtl/irq_stack_ptr.sv
module irq_stack_ptr #(
    parameter int             AW      = 8,
    parameter logic [AW-1:0]  SP_INIT = 8'h07
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_i,
    input  logic          dec_i,
    output logic [AW-1:0] sp_o
);
    logic [AW-1:0] sp_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     sp_q <= SP_INIT;
        else if (inc_i) sp_q <= sp_q + AW'(1);
        else if (dec_i) sp_q <= sp_q - AW'(1);
    end

    assign sp_o = sp_q;
endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_seq_pkg::*;
#(
    parameter int               NSRC     = 5,
    parameter int               PCW      = 16,
    parameter int               SPW      = 8,
    parameter logic [SPW-1:0]   SP_INIT  = 8'h07,
    parameter int               VEC_BASE = 3,
    parameter int               VEC_STEP = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gie_i,
    input  logic [NSRC-1:0] req_i,
    input  logic [NSRC-1:0] en_i,
    input  logic [NSRC-1:0] prio_i,
    input  logic [PCW-1:0]  pc_i,
    input  logic            reti_i,
    output logic [SPW-1:0]  mem_addr_o,
    output logic [PCW/2-1:0] mem_wdata_o,
    output logic            mem_we_o,
    input  logic [PCW/2-1:0] mem_rdata_i,
    output logic [SPW-1:0]  sp_o,
    output logic            pc_load_o,
    output logic [PCW-1:0]  pc_val_o,
    output logic [1:0]      in_service_o,
    output logic            cpu_hold_o
);
    localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1;
    localparam int BW   = PCW / 2;

    seq_state_t      state_q, state_d;
    logic            win_valid, win_hi;
    logic [IDXW-1:0] win_idx;
    logic [1:0]      isr;
    logic [SPW-1:0]  sp;
    logic            take_irq, take_ret;
    logic [IDXW-1:0] cap_idx_q;
    logic            cap_hi_q;
    logic [PCW-1:0]  cap_pc_q;
    logic [BW-1:0]   pop_hi_q, pop_lo_q;
    logic [PCW-1:0]  vec_addr;

    irq_arbiter #(.NSRC(NSRC), .IDXW(IDXW)) arb_i (
        .req_i       (req_i),
        .en_i        (en_i),
        .prio_i      (prio_i),
        .gie_i       (gie_i),
        .blk_hi_i    (isr[1]),
        .blk_lo_i    (isr[1] | isr[0]),
        .win_valid_o (win_valid),
        .win_hi_o    (win_hi),
        .win_idx_o   (win_idx)
    );

    irq_level_track lvl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (state_q == ST_VECTOR),
        .set_hi_i (cap_hi_q),
        .clr_i    (state_q == ST_RESUME),
        .isr_o    (isr)
    );

    irq_stack_ptr #(.AW(SPW), .SP_INIT(SP_INIT)) sp_i (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i ((state_q == ST_PUSH_LO) || (state_q == ST_PUSH_HI)),
        .dec_i ((state_q == ST_POP_HI) || (state_q == ST_POP_LO)),
        .sp_o  (sp)
    );

    // return strobe outranks a new request in the same idle cycle
    assign take_ret = (state_q == ST_IDLE) && reti_i;
    assign take_irq = (state_q == ST_IDLE) && !reti_i && win_valid;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_ret)      state_d = ST_POP_HI;
                else if (take_irq) state_d = ST_PUSH_LO;
            end
            ST_PUSH_LO: state_d = ST_PUSH_HI;
            ST_PUSH_HI: state_d = ST_VECTOR;
            ST_VECTOR:  state_d = ST_IDLE;
            ST_POP_HI:  state_d = ST_POP_LO;
            ST_POP_LO:  state_d = ST_RESUME;
            ST_RESUME:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // captured context and popped bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_idx_q <= '0;
            cap_hi_q  <= 1'b0;
            cap_pc_q  <= '0;
            pop_hi_q  <= '0;
            pop_lo_q  <= '0;
        end else begin
            if (take_irq) begin
                cap_idx_q <= win_idx;
                cap_hi_q  <= win_hi;
                cap_pc_q  <= pc_i;
            end
            if (state_q == ST_POP_HI) pop_hi_q <= mem_rdata_i;
            if (state_q == ST_POP_LO) pop_lo_q <= mem_rdata_i;
        end
    end

    assign vec_addr = PCW'(VEC_BASE) + PCW'(VEC_STEP) * PCW'(cap_idx_q);

    // outputs
    always_comb begin
        mem_addr_o  = sp;
        mem_wdata_o = '0;
        mem_we_o    = 1'b0;
        pc_load_o   = 1'b0;
        pc_val_o    = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PUSH_LO: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = sp + SPW'(1);
                mem_wdata_o = cap_pc_q[BW-1:0];
            end
            ST_PUSH_HI: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = sp + SPW'(1);
                mem_wdata_o = cap_pc_q[PCW-1:BW];
            end
            ST_VECTOR: begin
                pc_load_o = 1'b1;
                pc_val_o  = vec_addr;
            end
            ST_POP_HI, ST_POP_LO: mem_addr_o = sp;
            ST_RESUME: begin
                pc_load_o = 1'b1;
                pc_val_o  = {pop_hi_q, pop_lo_q};
            end
            default: ;
        endcase
    end

    assign sp_o         = sp;
    assign in_service_o = isr;
    assign cpu_hold_o   = (state_q != ST_IDLE);
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
    parameter int SPW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           mem_we_o,
    input logic [SPW-1:0] mem_addr_o,
    input logic [SPW-1:0] sp_o,
    input logic           pc_load_o,
    input logic [1:0]     in_service_o,
    input logic           cpu_hold_o
);
    p_push_above_sp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (mem_addr_o == SPW'(sp_o + SPW'(1))));

    p_push_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && !$past(mem_we_o)) |=>
            (mem_we_o && mem_addr_o == SPW'($past(mem_addr_o) + SPW'(1))));

    p_vector_after_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && $past(mem_we_o)) |=> pc_load_o);

    p_hi_blocks_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_service_o[1] |-> !mem_we_o);

    p_level_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_hold_o && !$past(cpu_hold_o)) |-> $stable(in_service_o));

    p_load_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load_o || mem_we_o) |-> cpu_hold_o);
endmodule

bind irq_seq irq_seq_chk #(.SPW(SPW)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .sp_o         (sp_o),
    .pc_load_o    (pc_load_o),
    .in_service_o (in_service_o),
    .cpu_hold_o   (cpu_hold_o)
);

// File: tb/irq_seq_tb.sv
module irq_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gie = 1'b0;
    logic [4:0]  req = '0, en = '0, prio = '0;
    logic [15:0] pc = '0;
    logic        reti = 1'b0;
    logic [7:0]  mem_addr, mem_wdata, mem_rdata, sp;
    logic        mem_we, pc_load, hold;
    logic [15:0] pc_val;
    logic [1:0]  isr;
    logic [7:0]  stk [256];
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    irq_seq dut_i (
        .clk(clk), .rst_n(rst_n), .gie_i(gie), .req_i(req), .en_i(en),
        .prio_i(prio), .pc_i(pc), .reti_i(reti), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_we_o(mem_we), .mem_rdata_i(mem_rdata),
        .sp_o(sp), .pc_load_o(pc_load), .pc_val_o(pc_val),
        .in_service_o(isr), .cpu_hold_o(hold)
    );

    assign mem_rdata = stk[mem_addr];
    always @(posedge clk) if (mem_we) stk[mem_addr] <= mem_wdata;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // caller drives the request at a negedge, then calls this
    task automatic expect_entry(input int idx, input logic [15:0] epc,
                                input int sp0, input int eisr, input string tag);
        @(negedge clk);
        chk({tag, " R2 lo we"}, mem_we, 1);
        chk({tag, " R2 lo addr"}, mem_addr, sp0 + 1);
        chk({tag, " R2 lo data"}, mem_wdata, epc[7:0]);
        chk({tag, " R9 hold"}, hold, 1);
        @(negedge clk);
        chk({tag, " R2 hi we"}, mem_we, 1);
        chk({tag, " R2 hi addr"}, mem_addr, sp0 + 2);
        chk({tag, " R2 hi data"}, mem_wdata, epc[15:8]);
        @(negedge clk);
        req = '0;
        chk({tag, " R3 load"}, pc_load, 1);
        chk({tag, " R3 vector"}, pc_val, 3 + 8 * idx);
        chk({tag, " R3 no we"}, mem_we, 0);
        @(negedge clk);
        chk({tag, " R8 level"}, isr, eisr);
        chk({tag, " R2 sp"}, sp, sp0 + 2);
        chk({tag, " R9 idle"}, hold, 0);
        chk({tag, " R3 one pulse"}, pc_load, 0);
    endtask

    task automatic expect_return(input logic [15:0] epc, input int sp0,
                                 input int eisr, input string tag);
        reti = 1'b1;
        @(negedge clk);
        reti = 1'b0;
        chk({tag, " R7 hi addr"}, mem_addr, sp0);
        chk({tag, " R7 no we"}, mem_we, 0);
        chk({tag, " R9 hold"}, hold, 1);
        @(negedge clk);
        chk({tag, " R7 lo addr"}, mem_addr, sp0 - 1);
        @(negedge clk);
        chk({tag, " R7 load"}, pc_load, 1);
        chk({tag, " R7 value"}, pc_val, epc);
        @(negedge clk);
        chk({tag, " R7 sp"}, sp, sp0 - 2);
        chk({tag, " R8 level"}, isr, eisr);
    endtask

    task automatic expect_ignored(input string tag);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk({tag, " hold"}, hold, 0);
            chk({tag, " we"}, mem_we, 0);
        end
    endtask

    task automatic t_reset();
        chk("R10 sp", sp, 8'h07);
        chk("R10 level", isr, 0);
        chk("R10 hold", hold, 0);
        chk("R10 load", pc_load, 0);
        chk("R10 we", mem_we, 0);
    endtask

    task automatic t_gate();
        gie = 1'b1; en = 5'b00000; req = 5'b00001;
        expect_ignored("R1 enable off");
        gie = 1'b0; en = 5'b11111;
        expect_ignored("R1 global off");
        req = '0; gie = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_single();
        prio = '0; pc = 16'h1234; req = 5'b00100;
        expect_entry(2, 16'h1234, 7, 2'b01, "single");
        expect_return(16'h1234, 9, 2'b00, "single");
    endtask

    task automatic t_poll();
        prio = '0; pc = 16'hBEEF; req = 5'b11010;
        expect_entry(1, 16'hBEEF, 7, 2'b01, "R4 poll");
        expect_return(16'hBEEF, 9, 2'b00, "R4 poll");
    endtask

    task automatic t_prio();
        prio = 5'b00100; pc = 16'h5A5A; req = 5'b00111;
        expect_entry(2, 16'h5A5A, 7, 2'b10, "R5 prio");
        expect_return(16'h5A5A, 9, 2'b00, "R5 prio");
        prio = '0;
    endtask

    task automatic t_nest();
        prio = 5'b00011; pc = 16'h0100; req = 5'b01000;
        expect_entry(3, 16'h0100, 7, 2'b01, "R6 outer");
        req = 5'b10000;
        expect_ignored("R6 low blocked");
        req = 5'b00001; pc = 16'h0200;
        expect_entry(0, 16'h0200, 9, 2'b11, "R6 preempt");
        req = 5'b00010;
        expect_ignored("R6 high blocked");
        req = '0;
        expect_return(16'h0200, 11, 2'b01, "R8 inner");
        expect_return(16'h0100, 9, 2'b00, "R8 outer");
        prio = '0;
    endtask

    task automatic t_simul();
        prio = 5'b10000; pc = 16'h4321; req = 5'b00010;
        expect_entry(1, 16'h4321, 7, 2'b01, "R11 setup");
        pc = 16'h7777; req = 5'b10000;
        expect_return(16'h4321, 9, 2'b00, "R11 return first");
        expect_entry(4, 16'h7777, 7, 2'b10, "R11 then entry");
        expect_return(16'h7777, 9, 2'b00, "R11 final");
        prio = '0;
    endtask

    initial begin
        for (int a = 0; a < 256; a++) stk[a] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        gie = 1'b1; en = 5'b11111;
        @(negedge clk);
        t_gate();
        en = 5'b11111;
        t_single();
        t_poll();
        t_prio();
        t_nest();
        t_simul();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule